// File: doc/BRIEF.md
# Workload Monitor with Operating-Point Selector

This block watches up to four independent task sources, each raising a one-cycle strobe whenever a task arrives. It adds every strobe into a single window count over an observation window whose length in clock cycles software sets. When a window closes, its count feeds an exponential moving average that serves as the rate estimate for the next interval. The estimate is scaled up to a prediction horizon that is a power-of-two multiple of the window. The scaled demand is then matched against a four-entry table of operating-point capacities.

The chosen operating point is the cheapest one whose capacity still covers the projected demand. Frequency costs switching energy linearly and voltage costs it quadratically, so the lowest adequate point saves the most. The index goes to an external supply and clock controller, together with a one-cycle update strobe. Voltage regulation and clock generation stay outside this block.

Top module: `wkld_dvfs_top`

## Requirements
- R1: Every strobe counts. When several sources strobe in the same cycle, the window count rises by the number of asserted strobes in that cycle.
- R2: A window lasts `win_len` cycles. A value below 4 is treated as 4. The cycle that closes a window is included in its count, and the next window starts counting from zero in the following cycle.
- R3: At each window close, the estimate E is replaced by E + floor((S − E) / 4), where S is the closed window count. The change is visible on `rate_est` two cycles after the closing cycle.
- R4: `rate_est` holds its value in every cycle where no new window count has arrived.
- R5: `opp_idx` changes only in a cycle where `opp_update` is high.
- R6: `opp_update` is high for exactly one cycle per window, three cycles after the closing cycle. It is never high in two consecutive cycles.
- R7: The index is the lowest i (0..3) with table entry i ≥ demand. If no entry is large enough, the index is 3. Entry i occupies bits [16·i+15 : 16·i] of `thr_table`.
- R8: The window count saturates at 65535 and does not wrap.
- R9: Demand equals `rate_est` shifted left by `horizon_sel` (0 to 3), saturated at 65535. `horizon_sel` is sampled in the cycle before the update.
- R10: While `rst_n` is low, `rate_est`, `opp_idx` and `opp_update` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_stb | input | 4 | One arrival strobe per source |
| win_len | input | 16 | Observation window length in cycles (minimum 4) |
| horizon_sel | input | 2 | Prediction horizon as log2 of window multiples |
| thr_table | input | 64 | Four 16-bit operating-point capacities, ascending |
| rate_est | output | 16 | Smoothed per-window arrival estimate |
| opp_idx | output | 2 | Requested operating-point index |
| opp_update | output | 1 | One-cycle strobe marking a new index |

## Verification
Each result has a fixed delay after the last cycle of a window. The closed count is registered one cycle later, `rate_est` shows the new average two cycles later, and `opp_idx` with `opp_update` appear three cycles later. A behavioural model in the bench advances on the same clock edge with integer arithmetic and keeps those delays. Every output is compared against it at each falling edge, so a result that arrives one cycle early or late is reported in the cycle where it differs. Stimulus covers sparse, pseudo-random and all-sources traffic, windows shorter than the minimum, every horizon setting, and a window long enough to saturate the count.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
    localparam int unsigned DEF_SRC_N   = 4;
    localparam int unsigned DEF_CNT_W   = 16;
    localparam int unsigned DEF_WIN_W   = 16;
    localparam int unsigned DEF_OPP_N   = 4;
    localparam int unsigned DEF_HZ_W    = 2;
    localparam int unsigned DEF_EMA_SH  = 2;
    localparam int unsigned DEF_MIN_WIN = 4;
endpackage

// File: rtl/wl_window_counter.sv
module wl_window_counter #(
    parameter int unsigned SRC_N   = dvfs_pkg::DEF_SRC_N,
    parameter int unsigned CNT_W   = dvfs_pkg::DEF_CNT_W,
    parameter int unsigned WIN_W   = dvfs_pkg::DEF_WIN_W,
    parameter int unsigned MIN_WIN = dvfs_pkg::DEF_MIN_WIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] stb_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic [CNT_W-1:0] smp_o,
    output logic             smp_vld_o
);
    localparam int unsigned PW = $clog2(SRC_N + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WIN_W-1:0] tmr;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] smp;
        logic             vld;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [PW-1:0]    pop;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sum_sat;
    logic [WIN_W-1:0] win_eff;
    logic             win_end;

    always_comb begin
        pop = '0;
        for (int i = 0; i < SRC_N; i++) begin
            pop = pop + PW'(stb_i[i]);
        end
        sum     = (CNT_W+1)'(st_q.acc) + (CNT_W+1)'(pop);
        sum_sat = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        win_eff = (win_len_i < WIN_W'(MIN_WIN)) ? WIN_W'(MIN_WIN) : win_len_i;
        win_end = ((WIN_W+1)'(st_q.tmr) + (WIN_W+1)'(1)) >= (WIN_W+1)'(win_eff);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (win_end) begin
            st_d.tmr = '0;
            st_d.acc = '0;
            st_d.smp = sum_sat;
            st_d.vld = 1'b1;
        end else begin
            st_d.tmr = st_q.tmr + WIN_W'(1);
            st_d.acc = sum_sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_o     = st_q.smp;
    assign smp_vld_o = st_q.vld;

    // R2: a closing cycle restarts the cycle count
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (st_q.tmr == '0));
    // R8: a full count stays full until the window closes
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc == CNT_MAX && !win_end) |=> (st_q.acc == CNT_MAX));
    // R1: inside a window the count never falls
    a_r1_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> (st_q.acc >= $past(st_q.acc)));
    // R6: window results never arrive back to back
    a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);
endmodule

// File: rtl/wl_rate_predictor.sv
module wl_rate_predictor #(
    parameter int unsigned CNT_W  = dvfs_pkg::DEF_CNT_W,
    parameter int unsigned EMA_SH = dvfs_pkg::DEF_EMA_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] smp_i,
    input  logic             smp_vld_i,
    output logic [CNT_W-1:0] est_o,
    output logic             est_vld_o
);
    typedef struct packed {
        logic [CNT_W-1:0] est;
        logic             vld;
    } pred_st_t;

    pred_st_t st_d, st_q;
    logic signed [CNT_W:0] diff;
    logic signed [CNT_W:0] step;
    logic signed [CNT_W:0] nxt;

    always_comb begin
        diff = $signed({1'b0, smp_i}) - $signed({1'b0, st_q.est});
        step = diff >>> EMA_SH;
        nxt  = $signed({1'b0, st_q.est}) + step;

        st_d     = st_q;
        st_d.vld = smp_vld_i;
        if (smp_vld_i) begin
            st_d.est = nxt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign est_o     = st_q.est;
    assign est_vld_o = st_q.vld;

    // R3: the new estimate lies between the old one and the window count
    a_r3_between: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld_i |=> ((st_q.est >= $past(st_q.est) && st_q.est <= $past(smp_i)) ||
                       (st_q.est <= $past(st_q.est) && st_q.est >= $past(smp_i))));
    // R4: no window count, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |=> $stable(st_q.est));
endmodule

// File: rtl/wl_opp_select.sv
module wl_opp_select #(
    parameter int unsigned CNT_W = dvfs_pkg::DEF_CNT_W,
    parameter int unsigned OPP_N = dvfs_pkg::DEF_OPP_N,
    parameter int unsigned HZ_W  = dvfs_pkg::DEF_HZ_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       est_i,
    input  logic                   est_vld_i,
    input  logic [HZ_W-1:0]        horizon_i,
    input  logic [OPP_N*CNT_W-1:0] thr_flat_i,
    output logic [$clog2(OPP_N)-1:0] opp_o,
    output logic                   upd_o
);
    localparam int unsigned OPP_W  = $clog2(OPP_N);
    localparam int unsigned SH_MAX = (1 << HZ_W) - 1;
    localparam int unsigned WIDE_W = CNT_W + SH_MAX;

    typedef struct packed {
        logic [OPP_W-1:0] opp;
        logic             upd;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic [CNT_W-1:0]  thr [OPP_N];
    logic [WIDE_W-1:0] wide;
    logic [CNT_W-1:0]  demand;
    logic [OPP_W-1:0]  pick;
    logic [CNT_W-1:0]  thr_here;
    logic [CNT_W-1:0]  thr_below;

    for (genvar g = 0; g < OPP_N; g++) begin : g_thr
        assign thr[g] = thr_flat_i[g*CNT_W +: CNT_W];
    end

    always_comb begin
        wide   = WIDE_W'(est_i) << horizon_i;
        demand = (|wide[WIDE_W-1:CNT_W]) ? '1 : wide[CNT_W-1:0];
        pick   = OPP_W'(OPP_N - 1);
        for (int i = OPP_N - 1; i >= 0; i--) begin
            if (thr[i] >= demand) begin
                pick = OPP_W'(i);
            end
        end

        st_d     = st_q;
        st_d.upd = est_vld_i;
        if (est_vld_i) begin
            st_d.opp = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign opp_o = st_q.opp;
    assign upd_o = st_q.upd;

    assign thr_here  = thr[st_q.opp];
    assign thr_below = (st_q.opp == '0) ? '0 : thr[st_q.opp - OPP_W'(1)];

    // R5: the index moves only together with the strobe
    a_r5_change_with_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.opp) |-> st_q.upd);
    // R7: the chosen entry covers the demand unless it is the top one
    a_r7_covers: assert property (@(posedge clk) disable iff (!rst_n)
        est_vld_i |=> (st_q.opp == OPP_W'(OPP_N - 1) || thr_here >= $past(demand)));
    // R7: the entry below the chosen one falls short
    a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        est_vld_i |=> (st_q.opp == '0 || thr_below < $past(demand)));
    // R6: the strobe lasts a single cycle
    a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |=> !st_q.upd);
endmodule

// File: rtl/wkld_dvfs_top.sv
module wkld_dvfs_top #(
    parameter int unsigned SRC_N   = dvfs_pkg::DEF_SRC_N,
    parameter int unsigned CNT_W   = dvfs_pkg::DEF_CNT_W,
    parameter int unsigned WIN_W   = dvfs_pkg::DEF_WIN_W,
    parameter int unsigned OPP_N   = dvfs_pkg::DEF_OPP_N,
    parameter int unsigned HZ_W    = dvfs_pkg::DEF_HZ_W,
    parameter int unsigned EMA_SH  = dvfs_pkg::DEF_EMA_SH,
    parameter int unsigned MIN_WIN = dvfs_pkg::DEF_MIN_WIN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SRC_N-1:0]         task_stb,
    input  logic [WIN_W-1:0]         win_len,
    input  logic [HZ_W-1:0]          horizon_sel,
    input  logic [OPP_N*CNT_W-1:0]   thr_table,
    output logic [CNT_W-1:0]         rate_est,
    output logic [$clog2(OPP_N)-1:0] opp_idx,
    output logic                     opp_update
);
    logic [CNT_W-1:0] smp;
    logic             smp_vld;
    logic             est_vld;

    wl_window_counter #(
        .SRC_N(SRC_N), .CNT_W(CNT_W), .WIN_W(WIN_W), .MIN_WIN(MIN_WIN)
    ) i_counter (
        .clk(clk), .rst_n(rst_n), .stb_i(task_stb), .win_len_i(win_len),
        .smp_o(smp), .smp_vld_o(smp_vld)
    );

    wl_rate_predictor #(
        .CNT_W(CNT_W), .EMA_SH(EMA_SH)
    ) i_predictor (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_vld_i(smp_vld),
        .est_o(rate_est), .est_vld_o(est_vld)
    );

    wl_opp_select #(
        .CNT_W(CNT_W), .OPP_N(OPP_N), .HZ_W(HZ_W)
    ) i_select (
        .clk(clk), .rst_n(rst_n), .est_i(rate_est), .est_vld_i(est_vld),
        .horizon_i(horizon_sel), .thr_flat_i(thr_table),
        .opp_o(opp_idx), .upd_o(opp_update)
    );

    // R10: all outputs are zero while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r10_reset: assert (rate_est == '0 && opp_idx == '0 && !opp_update);
        end
    end
endmodule

// File: tb/test_wkld_dvfs_top.sv
module test_wkld_dvfs_top;
    localparam int MAXV = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  task_stb = '0;
    logic [15:0] win_len = 16'd8;
    logic [1:0]  horizon_sel = '0;
    logic [63:0] thr_table;
    logic [15:0] rate_est;
    logic [1:0]  opp_idx;
    logic        opp_update;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    string tag = "R10";
    int mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // thresholds: entry0=8, entry1=24, entry2=64, entry3=200
    int thr_m [4] = '{8, 24, 64, 200};

    // reference model state
    int m_tmr = 0, m_acc = 0, m_smp = 0, m_est = 0, m_opp = 0;
    bit m_smp_v = 0, m_est_v = 0, m_upd = 0;

    assign thr_table = {16'd200, 16'd64, 16'd24, 16'd8};

    wkld_dvfs_top i_wkld_dvfs_top (
        .clk(clk), .rst_n(rst_n), .task_stb(task_stb), .win_len(win_len),
        .horizon_sel(horizon_sel), .thr_table(thr_table),
        .rate_est(rate_est), .opp_idx(opp_idx), .opp_update(opp_update)
    );

    always #5 clk = ~clk;

    function automatic int pick_opp(int est, int hz);
        int dem = est << hz;
        if (dem > MAXV) dem = MAXV;
        for (int i = 0; i < 4; i++) begin
            if (thr_m[i] >= dem) return i;
        end
        return 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = 0; m_acc = 0; m_smp = 0; m_est = 0; m_opp = 0;
            m_smp_v = 0; m_est_v = 0; m_upd = 0;
        end else begin
            int weff, pop, s, diff;
            // selection stage (R7, R9)
            m_upd = m_est_v;
            if (m_est_v) m_opp = pick_opp(m_est, int'(horizon_sel));
            // averaging stage (R3)
            m_est_v = m_smp_v;
            if (m_smp_v) begin
                diff = m_smp - m_est;
                m_est = m_est + (diff >>> 2);
            end
            // window stage (R1, R2, R8)
            weff = (int'(win_len) < 4) ? 4 : int'(win_len);
            pop = $countones(task_stb);
            s = m_acc + pop;
            if (s > MAXV) s = MAXV;
            if (m_tmr + 1 >= weff) begin
                m_smp = s; m_smp_v = 1; m_tmr = 0; m_acc = 0;
            end else begin
                m_smp_v = 0; m_tmr = m_tmr + 1; m_acc = s;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            check(tag, "rate_est (R3/R4)", int'(rate_est), m_est);
            check(tag, "opp_idx (R5/R7)", int'(opp_idx), m_opp);
            check(tag, "opp_update (R6)", int'(opp_update), int'(m_upd));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: task_stb = 4'b0000;
                1: task_stb = 4'b1111;
                2: task_stb = lfsr[3:0];
                default: task_stb = (cyc % 3 == 0) ? 4'b0101 : 4'b0010;
            endcase
        end
    end

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        // R10: reset state
        tag = "R10";
        wait_cycles(4);
        rst_n = 1'b1;
        // R1: simultaneous strobes from several sources, pseudo-random
        tag = "R1";
        mode = 2;
        wait_cycles(400);
        // R6 and R5: mixed pattern, index moves only with strobe
        tag = "R6";
        mode = 3;
        win_len = 16'd12;
        wait_cycles(300);
        // R9: all sources every cycle under each horizon
        tag = "R9";
        mode = 1;
        win_len = 16'd16;
        for (int h = 0; h < 4; h++) begin
            horizon_sel = 2'(h);
            wait_cycles(200);
        end
        // R4 and R3: silence lets the estimate decay
        tag = "R4";
        mode = 0;
        horizon_sel = 2'd0;
        wait_cycles(500);
        // R2: window below the minimum is clamped
        tag = "R2";
        mode = 2;
        win_len = 16'd1;
        wait_cycles(200);
        win_len = 16'd0;
        wait_cycles(100);
        // R7: sweep through table entries with sparse traffic
        tag = "R7";
        mode = 3;
        win_len = 16'd40;
        wait_cycles(800);
        // R8: long window saturates the count
        tag = "R8";
        mode = 1;
        win_len = 16'd20000;
        horizon_sel = 2'd3;
        wait_cycles(40020);
        tag = "R3";
        mode = 0;
        win_len = 16'd6;
        wait_cycles(200);
        finish_run();
    end

    initial begin
        wait_cycles(150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end
endmodule